// File: doc/BRIEF.md
# Bidirectional Mailbox Ports

This block holds a small set of byte-wide mailboxes shared by a host processor and an audio coprocessor. Each mailbox has two independent registers, one for each direction. The host writes a register that only the coprocessor reads. The coprocessor writes a register that only the host reads. Both sides use the same mailbox number, but a value sent one way never shows up in the other direction.

The coprocessor sees the mailboxes as a window of consecutive addresses in its I/O page (by default 0x00F4 to 0x00F7). It has one control address (by default 0x00F1). Writing that address with selected bits set clears, in pairs, the registers that the host fills. The host picks a mailbox with a 2-bit index. Both sides run on one clock. Reads are combinational from the selected register, and writes take effect at the next rising edge.

Top module: `mailbox_ports`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, every register in both directions reads 0x00 from its reader's side.
- R2: A coprocessor write to address PORT_BASE+n (n = 0..3) loads the host-readable register of mailbox n from the next cycle on. The coprocessor-readable registers and the other mailboxes do not change.
- R3: A coprocessor read at PORT_BASE+n returns the register most recently loaded by the host for mailbox n. A coprocessor read at any address outside the window returns 0x00.
- R4: The host read data equals the coprocessor-written register of the mailbox chosen by the host index, in the same cycle the index is presented.
- R5: A host write with index n loads the coprocessor-readable register of mailbox n from the next cycle on. The host-readable registers and the other mailboxes do not change.
- R6: A coprocessor write to CTRL_ADDR with bit 4 set clears the coprocessor-readable registers of mailboxes 0 and 1. With bit 5 set it clears those of mailboxes 2 and 3. No host-readable register is touched.
- R7: When a clear and a host write hit the same register in the same cycle, the register takes the host data.
- R8: A control write with bits 4 and 5 both zero changes nothing. A coprocessor write to an address that is neither the window nor CTRL_ADDR changes nothing. This includes an address whose low byte matches but whose upper byte differs.
- R9: A coprocessor write and a host write to the same mailbox in the same cycle both take effect, each in its own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both processors |
| rst_n | input | 1 | Synchronous reset, active low |
| cop_addr | input | 16 | Coprocessor address |
| cop_wr | input | 1 | Coprocessor write strobe |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Coprocessor read data (host-written register, or 0x00 outside the window) |
| host_idx | input | 2 | Mailbox number selected by the host |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (coprocessor-written register) |

## Verification
The stimulus first fills each direction with values that differ per mailbox and per direction. The reads then show whether a write landed in the wrong direction or the wrong mailbox. Clears are tried with bit 4 alone, bit 5 alone, both bits together, and neither bit. A collision of a clear with a host write in the same cycle separates write-wins priority from clear-wins priority. Addresses just below and above the window, and one aliased in the upper byte, expose a decode that is too wide. A long pseudo-random run then mixes reads, writes and clears from both sides against a cycle-by-cycle reference model.

// File: rtl/mbx_pkg.sv
// Package: shared defaults for the mailbox port block.
// Assumes a single clock for both processors.
package mbx_pkg;
    localparam int unsigned MBX_DATA_W    = 8;
    localparam int unsigned MBX_PORTS     = 4;
    localparam int unsigned MBX_ADDR_W    = 16;
    localparam int unsigned MBX_PORT_BASE = 16'h00F4;
    localparam int unsigned MBX_CTRL_ADDR = 16'h00F1;
    localparam int unsigned MBX_CLR_LSB   = 4;
endpackage

// File: rtl/mbx_addr_dec.sv
// Module: coprocessor address decoder.
// Turns a coprocessor address into a one-hot mailbox write enable, a
// control-register write strobe and a read index with a hit flag.
// Assumes NUM_PORTS is a power of two.
module mbx_addr_dec #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_BASE = 16'h00F4,
    parameter int unsigned CTRL_ADDR = 16'h00F1,
    localparam int unsigned IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    output logic [NUM_PORTS-1:0] port_we,
    output logic                 ctrl_we,
    output logic                 rd_hit,
    output logic [IDX_W-1:0]     rd_idx
);
    logic [ADDR_W-1:0] offset;

    // Offset of the address from the start of the mailbox window.
    always_comb begin
        offset  = addr - ADDR_W'(PORT_BASE);
        rd_hit  = (offset < ADDR_W'(NUM_PORTS));
        rd_idx  = offset[IDX_W-1:0];
        ctrl_we = wr && (addr == ADDR_W'(CTRL_ADDR));
    end

    // One write enable per mailbox.
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_we
        assign port_we[i] = wr && rd_hit && (rd_idx == IDX_W'(i));
    end

    // R2
    port_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_we));
endmodule

// File: rtl/mbx_latch_bank.sv
// Module: a bank of byte registers, one per mailbox, for one direction.
// Each register has a write enable and a clear. A write wins over a
// clear in the same cycle. Reset is synchronous and active low.
module mbx_latch_bank #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned NUM_PORTS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             wr_en,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [NUM_PORTS-1:0]             clr,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] q
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_reg
        // Hold, load or clear one mailbox register.
        always_ff @(posedge clk) begin
            if (!rst_n)         q[i] <= '0;
            else if (wr_en[i])  q[i] <= wr_data;
            else if (clr[i])    q[i] <= '0;
        end

        // R2 R5 R7
        load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |=> (q[i] == $past(wr_data)));

        // R6
        clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !wr_en[i]) |=> (q[i] == '0));

        // R8
        idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !wr_en[i]) |=> $stable(q[i]));
    end
endmodule

// File: rtl/mailbox_ports.sv
// Module: bidirectional mailbox ports between a host and a coprocessor.
// Two register banks, one per direction, share one mailbox number. The
// coprocessor reaches them through an address window, and its control
// register clears host-written mailboxes in pairs. One shared clock;
// synchronous active-low reset.
module mailbox_ports
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W    = MBX_DATA_W,
    parameter int unsigned NUM_PORTS = MBX_PORTS,
    parameter int unsigned ADDR_W    = MBX_ADDR_W,
    parameter int unsigned PORT_BASE = MBX_PORT_BASE,
    parameter int unsigned CTRL_ADDR = MBX_CTRL_ADDR,
    parameter int unsigned CLR_LSB   = MBX_CLR_LSB,
    localparam int unsigned IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int unsigned NUM_PAIRS = NUM_PORTS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cop_addr,
    input  logic              cop_wr,
    input  logic [DATA_W-1:0] cop_wdata,
    output logic [DATA_W-1:0] cop_rdata,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic [NUM_PORTS-1:0]             cop_port_we;
    logic                             cop_ctrl_we;
    logic                             cop_rd_hit;
    logic [IDX_W-1:0]                 cop_rd_idx;
    logic [NUM_PORTS-1:0]             host_port_we;
    logic [NUM_PORTS-1:0]             to_cop_clr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] to_cop_q;
    logic [NUM_PORTS-1:0][DATA_W-1:0] to_host_q;

    mbx_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_PORTS (NUM_PORTS),
        .PORT_BASE (PORT_BASE),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (cop_addr),
        .wr      (cop_wr),
        .port_we (cop_port_we),
        .ctrl_we (cop_ctrl_we),
        .rd_hit  (cop_rd_hit),
        .rd_idx  (cop_rd_idx)
    );

    // Host write enables, one per mailbox.
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_host_we
        assign host_port_we[i] = host_wr && (host_idx == IDX_W'(i));
    end

    // Pair clears: control bit CLR_LSB+k clears mailboxes 2k and 2k+1.
    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        assign to_cop_clr[2*k]   = cop_ctrl_we && cop_wdata[CLR_LSB+k];
        assign to_cop_clr[2*k+1] = cop_ctrl_we && cop_wdata[CLR_LSB+k];

        // R6
        pair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cop_ctrl_we && cop_wdata[CLR_LSB+k] && !host_port_we[2*k])
            |=> (to_cop_q[2*k] == '0));
    end
    if (NUM_PORTS % 2 == 1) begin : g_odd
        assign to_cop_clr[NUM_PORTS-1] = 1'b0;
    end

    // Host-to-coprocessor direction (clearable by the coprocessor).
    mbx_latch_bank #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) u_to_cop (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_port_we),
        .wr_data (host_wdata),
        .clr     (to_cop_clr),
        .q       (to_cop_q)
    );

    // Coprocessor-to-host direction (never cleared).
    mbx_latch_bank #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) u_to_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cop_port_we),
        .wr_data (cop_wdata),
        .clr     ('0),
        .q       (to_host_q)
    );

    // Read muxes for both sides.
    always_comb begin
        cop_rdata  = cop_rd_hit ? to_cop_q[cop_rd_idx] : '0;
        host_rdata = to_host_q[host_idx];
    end

    // R3
    cop_miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cop_rd_hit |-> (cop_rdata == '0));

    // R9
    both_dirs_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_wr && cop_rd_hit && host_wr && (host_idx == cop_rd_idx))
        |=> (to_host_q[$past(host_idx)] == $past(cop_wdata)
             && to_cop_q[$past(host_idx)] == $past(host_wdata)));
endmodule

// File: tb/mailbox_ports_test.sv
module mailbox_ports_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cop_addr = 16'h0000;
    logic        cop_wr = 1'b0;
    logic [7:0]  cop_wdata = 8'h00;
    logic [7:0]  cop_rdata;
    logic [1:0]  host_idx = 2'd0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model: to_cop[n] read by coprocessor, to_host[n] read by host
    int to_cop [4];
    int to_host[4];

    always #4 clk = ~clk;

    mailbox_ports uut (
        .clk(clk), .rst_n(rst_n),
        .cop_addr(cop_addr), .cop_wr(cop_wr), .cop_wdata(cop_wdata), .cop_rdata(cop_rdata),
        .host_idx(host_idx), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // model update at every rising edge: clears first, host write last (R7)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin to_cop[i] = 0; to_host[i] = 0; end
        end else begin
            if (cop_wr && cop_addr >= 16'h00F4 && cop_addr <= 16'h00F7)
                to_host[cop_addr - 16'h00F4] = cop_wdata;
            if (cop_wr && cop_addr == 16'h00F1) begin
                if (cop_wdata[4]) begin to_cop[0] = 0; to_cop[1] = 0; end
                if (cop_wdata[5]) begin to_cop[2] = 0; to_cop[3] = 0; end
            end
            if (host_wr) to_cop[host_idx] = host_wdata;
        end
    end

    function automatic int cop_exp(input logic [15:0] a);
        if (a >= 16'h00F4 && a <= 16'h00F7) return to_cop[a - 16'h00F4];
        return 0;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input int exp);
        checks++;
        if (act !== exp[7:0]) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp[7:0], $time);
        end
    endtask

    // drive one cycle after the falling edge, compare both read ports to model
    task automatic cyc(input logic [15:0] ca, input logic cw, input logic [7:0] cd,
                       input logic [1:0] hi, input logic hw, input logic [7:0] hd,
                       input string tag);
        @(negedge clk);
        cop_addr = ca; cop_wr = cw; cop_wdata = cd;
        host_idx = hi; host_wr = hw; host_wdata = hd;
        #1;
        check({tag, " cop side"}, cop_rdata, cop_exp(ca));
        check({tag, " host side"}, host_rdata, to_host[hi]);
    endtask

    task automatic peek(input int n, input string tag);
        cyc(16'h00F4 + 16'(n), 1'b0, 8'h00, 2'(n), 1'b0, 8'h00, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1 in reset
        for (int n = 0; n < 4; n++) begin
            peek(n, "R1 reset");
            check("R1 cop literal", cop_rdata, 0);
            check("R1 host literal", host_rdata, 0);
        end
        @(negedge clk); rst_n = 1'b1;
        for (int n = 0; n < 4; n++) peek(n, "R1 after release");

        // R2: coprocessor fills host-readable side
        for (int n = 0; n < 4; n++)
            cyc(16'h00F4 + 16'(n), 1'b1, 8'hA0 + 8'(n), 2'd0, 1'b0, 8'h00, "R2 write");
        for (int n = 0; n < 4; n++) begin
            peek(n, "R2 R4 readback");
            check("R4 host literal", host_rdata, 'hA0 + n);
            check("R2 cop side untouched", cop_rdata, 0);
        end

        // R5: host fills coprocessor-readable side
        for (int n = 0; n < 4; n++)
            cyc(16'h0000, 1'b0, 8'h00, 2'(n), 1'b1, 8'h10 + 8'(n), "R5 write");
        for (int n = 0; n < 4; n++) begin
            peek(n, "R3 R5 readback");
            check("R3 cop literal", cop_rdata, 'h10 + n);
            check("R5 host side untouched", host_rdata, 'hA0 + n);
        end

        // R6: clear pair 0/1
        cyc(16'h00F1, 1'b1, 8'h10, 2'd0, 1'b0, 8'h00, "R6 clr01");
        for (int n = 0; n < 4; n++) begin
            peek(n, "R6 after clr01");
            check("R6 clr01 literal", cop_rdata, (n < 2) ? 0 : 'h10 + n);
            check("R6 host kept", host_rdata, 'hA0 + n);
        end
        // R6: clear pair 2/3
        cyc(16'h00F1, 1'b1, 8'h20, 2'd0, 1'b0, 8'h00, "R6 clr23");
        peek(3, "R6 after clr23");
        check("R6 clr23 literal", cop_rdata, 0);

        // R7: both pairs cleared while host writes mailbox 1
        for (int n = 0; n < 4; n++)
            cyc(16'h0000, 1'b0, 8'h00, 2'(n), 1'b1, 8'h50 + 8'(n), "R5 refill");
        cyc(16'h00F1, 1'b1, 8'h30, 2'd1, 1'b1, 8'h77, "R7 collide");
        peek(1, "R7 after");
        check("R7 host wins", cop_rdata, 'h77);
        peek(0, "R7 neighbour");
        check("R7 neighbour cleared", cop_rdata, 0);

        // R8: no-op control and stray addresses
        for (int n = 0; n < 4; n++)
            cyc(16'h0000, 1'b0, 8'h00, 2'(n), 1'b1, 8'h60 + 8'(n), "R5 refill2");
        cyc(16'h00F1, 1'b1, 8'h00, 2'd0, 1'b0, 8'h00, "R8 ctrl zero");
        cyc(16'h00F1, 1'b1, 8'hCF, 2'd0, 1'b0, 8'h00, "R8 ctrl other bits");
        cyc(16'h00F3, 1'b1, 8'hEE, 2'd0, 1'b0, 8'h00, "R8 below window");
        cyc(16'h00F8, 1'b1, 8'hEE, 2'd0, 1'b0, 8'h00, "R8 above window");
        cyc(16'h01F4, 1'b1, 8'hEE, 2'd0, 1'b0, 8'h00, "R8 upper alias");
        check("R3 alias reads zero", cop_rdata, 0);
        for (int n = 0; n < 4; n++) begin
            peek(n, "R8 readback");
            check("R8 cop literal", cop_rdata, 'h60 + n);
            check("R8 host literal", host_rdata, 'hA0 + n);
        end

        // R9: both sides write mailbox 2 at once
        cyc(16'h00F6, 1'b1, 8'hC3, 2'd2, 1'b1, 8'h3C, "R9 both");
        peek(2, "R9 after");
        check("R9 host side", host_rdata, 'hC3);
        check("R9 cop side", cop_rdata, 'h3C);

        // mixed pseudo-random traffic against the model (R2 R3 R4 R5 R6 R7)
        for (int t = 0; t < 400; t++) begin
            logic [15:0] a;
            int r;
            r = $urandom % 12;
            a = (r < 10) ? 16'h00F0 + 16'(r) : 16'h01F5;
            cyc(a, 1'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
                "R2 R3 R4 R5 R6 R7 mixed");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule